// File: doc/BRIEF.md
# Preset-Based Multi-Mode Up/Down Counter

This block is one counting channel that sits behind an encoder front end. Each cycle the front end may raise a count strobe and give the direction of that step. The counter then moves one step up or down, unless its count mode says otherwise. Four count modes are available, and each one takes its boundary from a preset word: free running, clamped between zero and the preset, stop after the first wrap, and cyclic over the range zero to preset.

A borrow flag and a carry flag record wraps of the full-width count. Both stay set until they are cleared. Software may XOR them to form one extra most significant bit, which gives an extended count range.

The preset can reach the counter in two ways. The first is an explicit transfer strobe. The second is an index input, which has two forms:
- In level form, a low index loads the preset directly.
- In synchronous form, the index level is compared with a polarity bit, and the load happens in step with the count strobe. This form is only honoured while the channel is in quadrature mode.

Top module: `preset_updown_counter`

## Requirements
- R1: After reset, `count` is 0, `carry` and `borrow` are 0 and `dir_up` is 0.
- R2: With `mode` = 0 (normal), each `cnt_en` pulse adds 1 when `cnt_up` = 1 and subtracts 1 when `cnt_up` = 0. The count wraps freely: all ones plus 1 gives 0, and 0 minus 1 gives all ones.
- R3: An increment from all ones to 0 sets `carry`, and a decrement from 0 to all ones sets `borrow`. Both flags then stay set until a `flag_clr` cycle clears them. A flag is cleared on the clock edge after `flag_clr`.
- R4: With `mode` = 1 (range limit), an up pulse at `count == preset` leaves the count unchanged, and a down pulse at `count == 0` leaves it unchanged. A pulse in the opposite direction moves the count again.
- R5: With `mode` = 2 (non-recycle), the step that wraps the count still happens. After it, further pulses are ignored. Any preset load enables counting again.
- R6: With `mode` = 3 (modulo-N), an up pulse at `count == preset` gives 0, and a down pulse at `count == 0` gives `preset`. Neither case changes a flag.
- R7: `load` copies `preset` into `count` on the next edge and takes priority over a `cnt_en` pulse in the same cycle.
- R8: In level index form, with `idx_en` = 1 and `idx_in` = 0, the preset is loaded on each edge, and no count pulse is needed. With `idx_en` = 0 or `idx_in` = 1, the index has no effect.
- R9: In synchronous index form (`idx_sync` = 1 and `quad_mode` = 1), the preset is loaded only in a cycle where `cnt_en` = 1 and `idx_in == idx_pol`. The load replaces that count step. Without a pulse, the index has no effect.
- R10: With `idx_sync` = 1 while `quad_mode` = 0, the index behaves in level form (active low).
- R11: `dir_up` takes the value of `cnt_up` from the most recent `cnt_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | One-cycle count strobe |
| cnt_up | input | 1 | Direction of the strobe, 1 = up |
| mode | input | 2 | Count mode: 0 normal, 1 range limit, 2 non-recycle, 3 modulo-N |
| preset | input | WIDTH | Preset and boundary value |
| load | input | 1 | Transfer preset into the count |
| flag_clr | input | 1 | Clear carry and borrow |
| quad_mode | input | 1 | Channel is fed from a quadrature decoder |
| idx_en | input | 1 | Enable preset load from the index |
| idx_sync | input | 1 | Request synchronous index form |
| idx_pol | input | 1 | Active level of the index in synchronous form |
| idx_in | input | 1 | Index input |
| count | output | WIDTH | Current count |
| carry | output | 1 | Sticky overflow flag |
| borrow | output | 1 | Sticky underflow flag |
| dir_up | output | 1 | Direction of the last count strobe |

## Verification
The bench goes after the following corner cases:
- **Normal-mode wraps and sticky flags.** A design that lost a flag on the next step would fail, as would one that raised a flag in modulo-N at the preset boundary.
- **The clamps of range-limit mode.** A design that kept clamping after the direction reversed would never leave the limit. One that did not clamp would pass the preset.
- **The non-recycle halt.** The bench checks both that the halt holds and that a load releases it. A design that cleared the halt on `flag_clr` alone, or never released it, shows a frozen or moving count where the other is expected.
- **Index handling.** The bench checks level loads without a pulse, synchronous loads that need a pulse and the right polarity, and the fallback to level form when quadrature mode is off. A design that confused these loads the preset in the wrong cycle.

// File: rtl/preset_updown_counter.sv
module preset_updown_counter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] preset,
  input  logic             load,
  input  logic             flag_clr,
  input  logic             quad_mode,
  input  logic             idx_en,
  input  logic             idx_sync,
  input  logic             idx_pol,
  input  logic             idx_in,
  output logic [WIDTH-1:0] count,
  output logic             carry,
  output logic             borrow,
  output logic             dir_up
);
  localparam logic [1:0] M_FREE = 2'd0;
  localparam logic [1:0] M_CLAMP = 2'd1;
  localparam logic [1:0] M_ONCE = 2'd2;
  localparam logic [1:0] M_CYCLE = 2'd3;
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic halted;
  logic [WIDTH-1:0] nxt;
  logic stall, wrap_up, wrap_dn;

  wire sync_ok = idx_sync & quad_mode;
  wire idx_hit = idx_en & (sync_ok ? (cnt_en & (idx_in == idx_pol)) : ~idx_in);
  wire reload  = load | idx_hit;
  wire step    = cnt_en & ~halted;
  wire at_top  = (count == ALL_ONES);
  wire at_zero = (count == '0);
  wire at_pre  = (count == preset);

  always_comb begin
    nxt     = cnt_up ? count + 1'b1 : count - 1'b1;
    stall   = 1'b0;
    wrap_up = cnt_up & at_top;
    wrap_dn = ~cnt_up & at_zero;
    case (mode)
      M_CLAMP: begin
        if (cnt_up ? at_pre : at_zero) begin
          stall   = 1'b1;
          wrap_up = 1'b0;
          wrap_dn = 1'b0;
        end
      end
      M_CYCLE: begin
        if (cnt_up && at_pre) begin
          nxt     = '0;
          wrap_up = 1'b0;
        end else if (!cnt_up && at_zero) begin
          nxt     = preset;
          wrap_dn = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
      halted <= 1'b0;
      dir_up <= 1'b0;
    end else begin
      if (cnt_en) dir_up <= cnt_up;
      if (flag_clr) begin
        carry  <= 1'b0;
        borrow <= 1'b0;
      end
      if (reload) begin
        count  <= preset;
        halted <= 1'b0;
      end else if (step && !stall) begin
        count <= nxt;
        if (wrap_up) carry <= 1'b1;
        if (wrap_dn) borrow <= 1'b1;
        if (mode == M_ONCE && (wrap_up || wrap_dn)) halted <= 1'b1;
      end
    end
  end

  wire unused_free = (M_FREE == mode);
endmodule

// File: rtl/preset_updown_counter_chk.sv
module preset_updown_counter_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cnt_up,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] preset,
  input logic             load,
  input logic             idx_en,
  input logic             flag_clr,
  input logic [WIDTH-1:0] count,
  input logic             carry,
  input logic             borrow,
  input logic             halted
);
  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(preset));

  // R3
  carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry && !flag_clr |=> carry);

  // R3
  borrow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    borrow && !flag_clr |=> borrow);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !cnt_en |=> !carry && !borrow);

  // R4
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 && cnt_en && cnt_up && count == preset && !load && !idx_en
    |=> $stable(count));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !load && !idx_en |=> $stable(count));

  // R6
  cycle_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 && cnt_en && !cnt_up && count == '0 && !load && !idx_en
    |=> count == $past(preset));
endmodule

bind preset_updown_counter preset_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up), .mode(mode),
  .preset(preset), .load(load), .idx_en(idx_en), .flag_clr(flag_clr),
  .count(count), .carry(carry), .borrow(borrow), .halted(halted)
);

// File: tb/tb_preset_updown_counter.sv
module tb_preset_updown_counter;
  localparam int W = 24;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 0, cnt_up = 0, load = 0, flag_clr = 0;
  logic quad_mode = 0, idx_en = 0, idx_sync = 0, idx_pol = 0, idx_in = 1;
  logic [1:0] mode = 0;
  logic [W-1:0] preset = 0;
  logic [W-1:0] count;
  logic carry, borrow, dir_up;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  preset_updown_counter #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up), .mode(mode),
    .preset(preset), .load(load), .flag_clr(flag_clr), .quad_mode(quad_mode),
    .idx_en(idx_en), .idx_sync(idx_sync), .idx_pol(idx_pol), .idx_in(idx_in),
    .count(count), .carry(carry), .borrow(borrow), .dir_up(dir_up)
  );

  // {clr, load, en, up, mode, preset, exp_count, exp_carry, exp_borrow}
  localparam logic [55:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b1,2'd0,24'd0,24'd1,1'b0,1'b0},              // R2
    {1'b0,1'b0,1'b1,1'b1,2'd0,24'd0,24'd2,1'b0,1'b0},              // R2
    {1'b0,1'b0,1'b1,1'b0,2'd0,24'd0,24'd1,1'b0,1'b0},              // R2
    {1'b0,1'b0,1'b1,1'b0,2'd0,24'd0,24'd0,1'b0,1'b0},              // R2
    {1'b0,1'b0,1'b1,1'b0,2'd0,24'd0,24'hFFFFFF,1'b0,1'b1},         // R3 borrow
    {1'b0,1'b0,1'b1,1'b1,2'd0,24'd0,24'd0,1'b1,1'b1},              // R3 carry
    {1'b1,1'b0,1'b0,1'b0,2'd0,24'd0,24'd0,1'b0,1'b0},              // R3 clear
    {1'b0,1'b1,1'b0,1'b0,2'd3,24'd3,24'd3,1'b0,1'b0},              // R7
    {1'b0,1'b0,1'b1,1'b1,2'd3,24'd3,24'd0,1'b0,1'b0},              // R6 up wrap
    {1'b0,1'b0,1'b1,1'b0,2'd3,24'd3,24'd3,1'b0,1'b0},              // R6 down reload
    {1'b0,1'b0,1'b1,1'b0,2'd3,24'd3,24'd2,1'b0,1'b0},              // R6
    {1'b0,1'b1,1'b0,1'b0,2'd1,24'd2,24'd2,1'b0,1'b0},              // R7
    {1'b0,1'b0,1'b1,1'b1,2'd1,24'd2,24'd2,1'b0,1'b0},              // R4 top hold
    {1'b0,1'b0,1'b1,1'b0,2'd1,24'd2,24'd1,1'b0,1'b0},              // R4 resume
    {1'b0,1'b0,1'b1,1'b0,2'd1,24'd2,24'd0,1'b0,1'b0},              // R4
    {1'b0,1'b0,1'b1,1'b0,2'd1,24'd2,24'd0,1'b0,1'b0},              // R4 zero hold
    {1'b0,1'b0,1'b1,1'b1,2'd1,24'd2,24'd1,1'b0,1'b0},              // R4 resume
    {1'b0,1'b1,1'b0,1'b0,2'd2,24'hFFFFFE,24'hFFFFFE,1'b0,1'b0},    // R7
    {1'b0,1'b0,1'b1,1'b1,2'd2,24'hFFFFFE,24'hFFFFFF,1'b0,1'b0},    // R5
    {1'b0,1'b0,1'b1,1'b1,2'd2,24'hFFFFFE,24'd0,1'b1,1'b0},         // R5 wrap
    {1'b0,1'b0,1'b1,1'b1,2'd2,24'hFFFFFE,24'd0,1'b1,1'b0},         // R5 halted
    {1'b0,1'b0,1'b1,1'b0,2'd2,24'hFFFFFE,24'd0,1'b1,1'b0},         // R5 halted
    {1'b0,1'b1,1'b1,1'b1,2'd2,24'd5,24'd5,1'b1,1'b0},              // R7 priority
    {1'b0,1'b0,1'b1,1'b1,2'd2,24'd5,24'd6,1'b1,1'b0},              // R5 re-enabled
    {1'b1,1'b0,1'b0,1'b0,2'd2,24'd5,24'd6,1'b0,1'b0}               // R3 clear
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 count", 32'(count), 0);
    chk("R1 flags", {30'd0, carry, borrow}, 0);
    chk("R1 dir", 32'(dir_up), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      flag_clr = VEC[i][55];
      load     = VEC[i][54];
      cnt_en   = VEC[i][53];
      cnt_up   = VEC[i][52];
      mode     = VEC[i][51:50];
      preset   = VEC[i][49:26];
      tick();
      chk($sformatf("vector %0d count", i), 32'(count), 32'(VEC[i][25:2]));
      chk($sformatf("vector %0d flags", i), {30'd0, carry, borrow}, {30'd0, VEC[i][1:0]});
    end
    flag_clr = 0; load = 0; cnt_en = 0;

    // R8 index disabled: no effect
    mode = 2'd0; preset = 24'd100; idx_en = 0; idx_in = 0;
    tick();
    chk("R8 disabled index", 32'(count), 6);
    // R8 level form, no pulse needed
    idx_en = 1;
    tick();
    chk("R8 level load", 32'(count), 100);
    // R8 inactive level ignored
    idx_in = 1; preset = 24'd50; cnt_en = 1; cnt_up = 1;
    tick();
    chk("R8 inactive level", 32'(count), 101);
    // R10 sync requested without quadrature: level form
    cnt_en = 0; idx_sync = 1; quad_mode = 0; idx_in = 0;
    tick();
    chk("R10 fallback level", 32'(count), 50);
    // R9 sync active level but no pulse: no load
    quad_mode = 1; idx_pol = 1; idx_in = 1; preset = 24'd7;
    tick();
    chk("R9 no pulse", 32'(count), 50);
    // R9 sync with pulse: load replaces step
    cnt_en = 1; cnt_up = 0;
    tick();
    chk("R9 sync load", 32'(count), 7);
    chk("R11 dir down", 32'(dir_up), 0);
    // R9 wrong level for polarity: counts
    idx_in = 0; cnt_up = 1;
    tick();
    chk("R9 wrong polarity", 32'(count), 8);
    chk("R11 dir up", 32'(dir_up), 1);
    // R9 polarity low
    idx_pol = 0; idx_in = 0;
    tick();
    chk("R9 low polarity", 32'(count), 7);
    // R11 direction held without pulse
    idx_en = 0; cnt_en = 0; cnt_up = 0;
    tick();
    chk("R11 dir held", 32'(dir_up), 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule